// File: doc/BRIEF.md
# Branch Hazard Control Unit

This unit controls a five-stage in-order pipeline around conditional equality branches. Each cycle it looks at a decoded-branch flag for the instruction in decode and at the result of the operand comparison for the branch being resolved. It then picks the next fetch address, holds fetch, or kills younger instructions that should not have been fetched. A small model of the pipeline is built in. It has a fetch PC and per-stage valid bits with instruction addresses through decode, execute, memory and writeback. This model lets the order of retired instructions be observed directly.

Three control policies can be selected, and the choice is captured only while reset is asserted. The policies are: stall fetch until the branch resolves; fetch sequentially and squash on a taken branch; or always execute one delay-slot instruction after the branch. The parameter `EARLY` picks where branches resolve. At 0 they resolve in execute, which gives a base penalty D = 2 cycles. At 1 they resolve in decode with an added comparator, which gives D = 1. The comparator itself lives outside the unit. The environment answers `cmp_eq` and `br_tgt` for the address shown on `rslv_pc`, and answers `id_br` for the address on `id_pc`.

Top module: `brhaz_ctrl`

## Requirements
- R1: While reset is asserted, `ret_v` is 0 and `fetch_pc` is 0. After reset the first retired address is 0, and non-branch code retires one address per cycle in ascending order.
- R2: `pol_in` is captured only while reset is high. The codes are 0 = stall, 1 = predict not taken, 2 = delay slot, and 3 behaves as stall. Changing `pol_in` after reset has no effect on the retired sequence or its timing.
- R3: Under the stall policy, every branch adds exactly D idle cycles after it, whether or not it is taken, where D = 2 when `EARLY`=0 and D = 1 when `EARLY`=1. While `if_hold` is high and no redirect occurs, `fetch_pc` stays unchanged.
- R4: Under predict not taken, a taken branch adds D idle cycles. The instructions fetched after it on the sequential path never retire.
- R5: Under predict not taken, a not-taken branch adds no idle cycle, and `if_hold` never rises.
- R6: Under the delay-slot policy, the instruction at branch+1 always retires in the cycle after the branch. A taken branch then adds D-1 idle cycles, which is 0 when `EARLY`=1, before the target retires. A not-taken branch adds none and continues at branch+2.
- R7: When `pc_sel` is high, `fetch_pc` in the next cycle equals the `br_tgt` presented with it.
- R8: A squashed entry becomes a bubble: its valid bit, which stands for all of its write and memory enables, is cleared. After `flush_if` the decode stage holds no valid instruction.
- R9: The retired address sequence follows program order for every policy and for both resolve stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures `pol_in` |
| pol_in | input | 2 | Policy code: 0 stall, 1 predict not taken, 2 delay slot, 3 stall |
| id_br | input | 1 | Instruction at `id_pc` is a conditional branch |
| cmp_eq | input | 1 | Comparison outcome (taken) for the branch at `rslv_pc` |
| br_tgt | input | AW | Target address for the branch at `rslv_pc` |
| fetch_pc | output | AW | Address being fetched this cycle |
| id_pc | output | AW | Address held in decode |
| rslv_pc | output | AW | Address in the resolving stage (decode or execute) |
| pc_sel | output | 1 | Redirect: next fetch address is `br_tgt` |
| if_hold | output | 1 | Fetch held this cycle |
| flush_if | output | 1 | Instruction fetched this cycle is squashed |
| flush_id | output | 1 | Instruction in decode is squashed |
| ret_v | output | 1 | An instruction retires this cycle |
| ret_pc | output | AW | Address of the retiring instruction |

## Verification
On every cycle the assertions check several behaviours. They check that a branch in decode under the stall policy leaves decode empty in the next cycle, and that a held fetch keeps its address. They check that a redirect lands on the presented target and that a squash empties decode. They also check that the captured policy never changes after reset, that predict not taken never holds fetch, and that the delay-slot instruction survives a taken branch. Only the bench scenarios can show the policy penalties as whole-cycle gaps between retirements, and that squashed instructions never retire. They also show that retirement follows program order for each policy at both resolve stages, and that a late change of `pol_in` is ignored.

// File: rtl/brhaz_ctrl.sv
module brhaz_ctrl #(
  parameter int AW    = 16,
  parameter bit EARLY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    pol_in,
  input  logic          id_br,
  input  logic          cmp_eq,
  input  logic [AW-1:0] br_tgt,
  output logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] id_pc,
  output logic [AW-1:0] rslv_pc,
  output logic          pc_sel,
  output logic          if_hold,
  output logic          flush_if,
  output logic          flush_id,
  output logic          ret_v,
  output logic [AW-1:0] ret_pc
);
  localparam logic [1:0] P_PNT = 2'd1;
  localparam logic [1:0] P_DLY = 2'd2;

  logic [1:0]    pol_q;
  logic [AW-1:0] pc_q, id_pc_q, ex_pc, mem_pc, wb_pc;
  logic          id_v, ex_v, ex_br, mem_v, wb_v;
  logic          is_pnt, is_dly, is_stall;
  logic          id_brv, ex_brv, r_v;

  assign is_pnt   = (pol_q == P_PNT);
  assign is_dly   = (pol_q == P_DLY);
  assign is_stall = !is_pnt && !is_dly;
  assign id_brv   = id_v && id_br;
  assign ex_brv   = ex_v && ex_br;

  generate
    if (EARLY) begin : g_res_id
      assign r_v     = id_brv;
      assign rslv_pc = id_pc_q;
    end else begin : g_res_ex
      assign r_v     = ex_brv;
      assign rslv_pc = ex_pc;
    end
  endgenerate

  assign pc_sel   = r_v && cmp_eq;
  assign if_hold  = is_stall && (id_brv || (EARLY ? 1'b0 : ex_brv));
  assign flush_if = pc_sel && (is_pnt || (is_dly && !EARLY));
  assign flush_id = pc_sel && is_pnt && !EARLY;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= pol_in;
      pc_q    <= '0;
      id_pc_q <= '0;
      ex_pc   <= '0;
      mem_pc  <= '0;
      wb_pc   <= '0;
      id_v    <= 1'b0;
      ex_v    <= 1'b0;
      ex_br   <= 1'b0;
      mem_v   <= 1'b0;
      wb_v    <= 1'b0;
    end else begin
      if (pc_sel)       pc_q <= br_tgt;
      else if (!if_hold) pc_q <= pc_q + 1'b1;
      id_v    <= !(if_hold || flush_if);
      id_pc_q <= pc_q;
      ex_v    <= id_v && !flush_id;
      ex_br   <= id_br;
      ex_pc   <= id_pc_q;
      mem_v   <= ex_v;
      mem_pc  <= ex_pc;
      wb_v    <= mem_v;
      wb_pc   <= mem_pc;
    end
  end

  assign fetch_pc = pc_q;
  assign id_pc    = id_pc_q;
  assign ret_v    = wb_v;
  assign ret_pc   = wb_pc;
endmodule

// File: rtl/brhaz_ctrl_chk.sv
module brhaz_ctrl_chk #(
  parameter int AW    = 16,
  parameter bit EARLY = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    pol_q,
  input logic          id_v,
  input logic          id_br,
  input logic          ex_v,
  input logic [AW-1:0] pc_q,
  input logic [AW-1:0] br_tgt,
  input logic          pc_sel,
  input logic          if_hold,
  input logic          flush_if
);
  assert_stall_gap_R3: assert property (@(posedge clk) disable iff (rst)
    ((pol_q == 2'd0 || pol_q == 2'd3) && id_v && id_br) |=> !id_v);

  assert_hold_pc_R3: assert property (@(posedge clk) disable iff (rst)
    (if_hold && !pc_sel) |=> $stable(pc_q));

  assert_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    pc_sel |=> (pc_q == $past(br_tgt)));

  assert_squash_R8: assert property (@(posedge clk) disable iff (rst)
    flush_if |=> !id_v);

  assert_pol_held_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(pol_q));

  assert_pnt_nohold_R5: assert property (@(posedge clk) disable iff (rst)
    (pol_q == 2'd1) |-> !if_hold);

  assert_slot_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (pol_q == 2'd2 && pc_sel) |=> (EARLY ? id_v : ex_v));
endmodule

bind brhaz_ctrl brhaz_ctrl_chk #(.AW(AW), .EARLY(EARLY)) u_chk (
  .clk(clk), .rst(rst), .pol_q(pol_q), .id_v(id_v), .id_br(id_br),
  .ex_v(ex_v), .pc_q(pc_q), .br_tgt(br_tgt), .pc_sel(pc_sel),
  .if_hold(if_hold), .flush_if(flush_if)
);

// File: tb/brhaz_ctrl_tb.sv
`timescale 1ns/1ps
module brhaz_ctrl_tb;
  localparam int AW   = 16;
  localparam int NRET = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] pol_in = 2'd0;
  always #5 clk = ~clk;

  function automatic logic is_br(input logic [AW-1:0] p);
    return p[2:0] == 3'd3;
  endfunction
  function automatic logic tk(input logic [AW-1:0] p);
    return p[3] == 1'b0;
  endfunction
  function automatic logic [AW-1:0] tgt(input logic [AW-1:0] p);
    return p + 16'd6;
  endfunction

  logic [AW-1:0] fpc [2], ipc [2], rpc [2], rtp [2];
  logic          sel [2], hold [2], fif [2], fid [2], rv [2];
  logic          idb [2], ceq [2];
  logic [AW-1:0] btg [2];

  always_comb begin
    for (int e = 0; e < 2; e++) begin
      idb[e] = is_br(ipc[e]);
      ceq[e] = tk(rpc[e]);
      btg[e] = tgt(rpc[e]);
    end
  end

  brhaz_ctrl #(.AW(AW), .EARLY(1'b0)) u_dut (
    .clk(clk), .rst(rst), .pol_in(pol_in), .id_br(idb[0]), .cmp_eq(ceq[0]),
    .br_tgt(btg[0]), .fetch_pc(fpc[0]), .id_pc(ipc[0]), .rslv_pc(rpc[0]),
    .pc_sel(sel[0]), .if_hold(hold[0]), .flush_if(fif[0]), .flush_id(fid[0]),
    .ret_v(rv[0]), .ret_pc(rtp[0]));

  brhaz_ctrl #(.AW(AW), .EARLY(1'b1)) u_dut_e (
    .clk(clk), .rst(rst), .pol_in(pol_in), .id_br(idb[1]), .cmp_eq(ceq[1]),
    .br_tgt(btg[1]), .fetch_pc(fpc[1]), .id_pc(ipc[1]), .rslv_pc(rpc[1]),
    .pc_sel(sel[1]), .if_hold(hold[1]), .flush_if(fif[1]), .flush_id(fid[1]),
    .ret_v(rv[1]), .ret_pc(rtp[1]));

  int total = 0;
  int bad = 0;
  int nret [2];
  int gapc [2];
  logic [AW-1:0] exp_pc  [2][NRET];
  int            exp_gap [2][NRET];
  string         exp_tag [2][NRET];
  logic          sel_d [2];
  logic [AW-1:0] tgt_d [2];
  logic          run = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic fill(input int pol, input int e);
    logic [AW-1:0] p, snext;
    int d, pend, spen;
    bit slot;
    string ptag, stag;
    p = '0; pend = 0; slot = 0; snext = '0; spen = 0;
    d = (e == 1) ? 1 : 2;
    ptag = "R1"; stag = "R6";
    for (int k = 0; k < NRET; k++) begin
      exp_pc[e][k]  = p;
      exp_gap[e][k] = 1 + pend;
      exp_tag[e][k] = ptag;
      pend = 0; ptag = "R9";
      if (slot) begin
        slot = 0; p = snext; pend = spen; ptag = stag;
      end else if (is_br(p)) begin
        case (pol)
          1: begin pend = tk(p) ? d : 0; ptag = tk(p) ? "R4" : "R5";
                   p = tk(p) ? tgt(p) : p + 1'b1; end
          2: begin slot = 1; snext = tk(p) ? tgt(p) : p + 16'd2;
                   spen = tk(p) ? d - 1 : 0; ptag = "R6"; p = p + 1'b1; end
          default: begin pend = d; ptag = "R3";
                   p = tk(p) ? tgt(p) : p + 1'b1; end
        endcase
      end else begin
        p = p + 1'b1;
      end
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      for (int e = 0; e < 2; e++) begin
        if (sel_d[e])
          chk(fpc[e] == tgt_d[e], "R7", "redirect target", int'(fpc[e]), int'(tgt_d[e]));
        sel_d[e] = sel[e];
        tgt_d[e] = btg[e];
        gapc[e]++;
        if (rv[e] && nret[e] < NRET) begin
          chk(rtp[e] == exp_pc[e][nret[e]], "R9", "retire order",
              int'(rtp[e]), int'(exp_pc[e][nret[e]]));
          if (nret[e] > 0)
            chk(gapc[e] == exp_gap[e][nret[e]], exp_tag[e][nret[e]],
                "retire gap", gapc[e], exp_gap[e][nret[e]]);
          nret[e]++;
          gapc[e] = 0;
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int pol = 0; pol < 4; pol++) begin
      for (int e = 0; e < 2; e++) begin
        fill(pol, e);
        nret[e] = 0; gapc[e] = 0; sel_d[e] = 1'b0; tgt_d[e] = '0;
      end
      rst = 1'b1;
      pol_in = pol[1:0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int e = 0; e < 2; e++) begin
        chk(rv[e] == 1'b0, "R1", "ret_v in reset", int'(rv[e]), 0);
        chk(fpc[e] == '0, "R1", "fetch_pc in reset", int'(fpc[e]), 0);
      end
      run = 1'b1;
      rst = 1'b0;
      begin
        int cyc;
        cyc = 0;
        while ((nret[0] < NRET || nret[1] < NRET) && cyc < 1000) begin
          @(negedge clk);
          cyc++;
          if (cyc == 8) pol_in = pol[1:0] ^ 2'd1; // R2: ignored after reset
        end
        chk(cyc < 1000, "R2", "run completes", cyc, 1000);
      end
      run = 1'b0;
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule